// File: doc/BRIEF.md
# Pattern-Driven Set/Clear/Toggle Level Machine

This block is a Moore state machine with two synchronous data inputs, `in_a` and `in_b`, and one output level, `z_out`. It samples the input pair on every rising clock edge. The output stays where it is until a two-step pattern finishes. A pattern always ends with both inputs high. The pair that came one clock before that end decides the effect: the output is cleared, set, inverted, or left alone.

The state holds two things: the present output level and the class of the previous input pair. Because of this, a pattern is recognised on the same edge that registers its final `11`. That final `11` then counts as the previous pair for the next edge, so patterns may overlap. The output is decoded from the state alone. It therefore moves only on a clock edge and never follows the inputs combinationally.

There are eight states, each named by its level and the pair it remembers. They are `LO_AFTER_00`, `LO_AFTER_01`, `LO_AFTER_10` and `LO_AFTER_11`, and `HI_AFTER_00` through `HI_AFTER_11`. The transitions work as follows:

- Any pair other than `11` moves the machine to the state with the same level that remembers that pair.
- A `11` always moves the machine to one of the `*_AFTER_11` states. The level of that state is chosen by the pair remembered in the old state: 0 after `00`, 1 after `01`, the inverse after `10`, and unchanged after `11`.
- Reset goes to `LO_AFTER_11`.

Top module: `seq_set_clear_toggle`

## Requirements
- R1: The input pair is the 2-bit value {in_a, in_b}, where in_a is the upper bit. It is sampled on the rising edge of clk. z_out is decoded from registered state only, so a change on the inputs between edges leaves z_out unchanged.
- R2: At any edge where the sampled pair is 00, 01 or 10, z_out keeps its value.
- R3: A pair 00 at one edge followed by 11 at the next edge makes z_out 0 after that second edge.
- R4: A pair 01 followed by 11 makes z_out 1 after the edge that registers the 11.
- R5: A pair 10 followed by 11 inverts z_out after the edge that registers the 11.
- R6: The 11 that ends a pattern is itself remembered as the previous pair. A 11 followed by another 11 therefore leaves z_out unchanged, and a pattern can start straight after another one ends.
- R7: While srst is high at a rising edge, the state is reset synchronously: z_out becomes 0 and the remembered pair becomes 11. The first 11 after reset therefore leaves z_out at 0, whatever pairs came before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | Upper bit of the sampled input pair |
| in_b | input | 1 | Lower bit of the sampled input pair |
| z_out | output | 1 | Held output level, decoded from the state |

## Verification
Two functions fall on the same edge whenever a `11` arrives: acting on the remembered pair, and recording the new `11` as the next remembered pair. The bench provokes this with back-to-back endings such as `10,11,10,11` and `11,11`. A cycle-accurate reference model judges each edge and expects a double toggle for the first and a hold for the second. Reset can also coincide with a half-finished pattern. The bench applies reset right after a `10` and then sends `11`. The model expects the output to stay 0, because the reset record of `11` must win over the discarded `10`.

// File: rtl/seq_sct_pkg.sv
`timescale 1ns/1ps
package seq_sct_pkg;

    localparam int PAIR_W  = 2;
    localparam int STATE_W = PAIR_W + 1;

    // Class of one sampled input pair, value equals {in_a, in_b}
    typedef enum logic [PAIR_W-1:0] {
        CLS_00 = 2'b00,
        CLS_01 = 2'b01,
        CLS_10 = 2'b10,
        CLS_11 = 2'b11
    } pair_cls_t;

    // Upper bit is the output level, lower bits the remembered pair class
    typedef enum logic [STATE_W-1:0] {
        LO_AFTER_00 = 3'b000,
        LO_AFTER_01 = 3'b001,
        LO_AFTER_10 = 3'b010,
        LO_AFTER_11 = 3'b011,
        HI_AFTER_00 = 3'b100,
        HI_AFTER_01 = 3'b101,
        HI_AFTER_10 = 3'b110,
        HI_AFTER_11 = 3'b111
    } fsm_state_t;

    localparam fsm_state_t RESET_STATE = LO_AFTER_11;

endpackage

// File: rtl/seq_sct_classify.sv
`timescale 1ns/1ps
module seq_sct_classify
    import seq_sct_pkg::*;
(
    input  logic      bit_hi,
    input  logic      bit_lo,
    output pair_cls_t cls
);

    always_comb begin
        unique case ({bit_hi, bit_lo})
            2'b00:   cls = CLS_00;
            2'b01:   cls = CLS_01;
            2'b10:   cls = CLS_10;
            default: cls = CLS_11;
        endcase
    end

endmodule

// File: rtl/seq_sct_next.sv
`timescale 1ns/1ps
module seq_sct_next
    import seq_sct_pkg::*;
(
    input  fsm_state_t cur,
    input  pair_cls_t  cls,
    output fsm_state_t nxt
);

    logic      cur_lvl;
    pair_cls_t cur_prev;
    logic      nxt_lvl;
    pair_cls_t nxt_prev;

    // Split the state into level and remembered pair
    always_comb begin
        unique case (cur)
            LO_AFTER_00: begin cur_lvl = 1'b0; cur_prev = CLS_00; end
            LO_AFTER_01: begin cur_lvl = 1'b0; cur_prev = CLS_01; end
            LO_AFTER_10: begin cur_lvl = 1'b0; cur_prev = CLS_10; end
            LO_AFTER_11: begin cur_lvl = 1'b0; cur_prev = CLS_11; end
            HI_AFTER_00: begin cur_lvl = 1'b1; cur_prev = CLS_00; end
            HI_AFTER_01: begin cur_lvl = 1'b1; cur_prev = CLS_01; end
            HI_AFTER_10: begin cur_lvl = 1'b1; cur_prev = CLS_10; end
            default:     begin cur_lvl = 1'b1; cur_prev = CLS_11; end
        endcase
    end

    // A completing 11 acts on the remembered pair; every pair is remembered
    always_comb begin
        nxt_prev = cls;
        unique case (cls)
            CLS_11: begin
                unique case (cur_prev)
                    CLS_00:  nxt_lvl = 1'b0;
                    CLS_01:  nxt_lvl = 1'b1;
                    CLS_10:  nxt_lvl = ~cur_lvl;
                    default: nxt_lvl = cur_lvl;
                endcase
            end
            default: nxt_lvl = cur_lvl;
        endcase
        nxt = fsm_state_t'({nxt_lvl, nxt_prev});
    end

endmodule

// File: rtl/seq_set_clear_toggle.sv
`timescale 1ns/1ps
module seq_set_clear_toggle
    import seq_sct_pkg::*;
(
    input  logic clk,
    input  logic srst,
    input  logic in_a,
    input  logic in_b,
    output logic z_out
);

    pair_cls_t  cls;
    fsm_state_t state_q;
    fsm_state_t state_d;
    pair_cls_t  prev_q;

    seq_sct_classify u_classify (
        .bit_hi (in_a),
        .bit_lo (in_b),
        .cls    (cls)
    );

    seq_sct_next u_next (
        .cur (state_q),
        .cls (cls),
        .nxt (state_d)
    );

    // State register
    always_ff @(posedge clk) begin
        if (srst) state_q <= RESET_STATE;
        else      state_q <= state_d;
    end

    // Moore output decode
    always_comb begin
        unique case (state_q)
            LO_AFTER_00, LO_AFTER_01, LO_AFTER_10, LO_AFTER_11: z_out = 1'b0;
            default:                                            z_out = 1'b1;
        endcase
    end

    assign prev_q = pair_cls_t'(state_q[PAIR_W-1:0]);

    // Marks that a reset has been seen, so history checks start cleanly
    logic armed_q;
    always_ff @(posedge clk) begin
        if (srst) armed_q <= 1'b1;
    end

    assert_clear_R3: assert property (@(posedge clk) disable iff (srst)
        (armed_q && !$past(srst) && $past(cls) == CLS_11 && $past(prev_q) == CLS_00)
        |-> (z_out == 1'b0))
        else $error("R3 clear pattern did not drive z_out low");

    assert_set_R4: assert property (@(posedge clk) disable iff (srst)
        (armed_q && !$past(srst) && $past(cls) == CLS_11 && $past(prev_q) == CLS_01)
        |-> (z_out == 1'b1))
        else $error("R4 set pattern did not drive z_out high");

    assert_toggle_R5: assert property (@(posedge clk) disable iff (srst)
        (armed_q && !$past(srst) && $past(cls) == CLS_11 && $past(prev_q) == CLS_10)
        |-> (z_out != $past(z_out)))
        else $error("R5 toggle pattern did not invert z_out");

    assert_hold_R2: assert property (@(posedge clk) disable iff (srst)
        (armed_q && !$past(srst) && $past(cls) != CLS_11)
        |-> $stable(z_out))
        else $error("R2 z_out moved without a completing 11");

    assert_hold_repeat_R6: assert property (@(posedge clk) disable iff (srst)
        (armed_q && !$past(srst) && $past(cls) == CLS_11 && $past(prev_q) == CLS_11)
        |-> $stable(z_out))
        else $error("R6 repeated 11 changed z_out");

    assert_prev_track_R6: assert property (@(posedge clk) disable iff (srst)
        (armed_q && !$past(srst))
        |-> (prev_q == $past(cls)))
        else $error("R6 remembered pair does not match last sampled pair");

    assert_reset_R7: assert property (@(posedge clk) disable iff (srst)
        $past(srst) |-> (z_out == 1'b0 && prev_q == CLS_11))
        else $error("R7 reset state wrong");

endmodule

// File: tb/seq_set_clear_toggle_test.sv
`timescale 1ns/1ps
module seq_set_clear_toggle_test;

    logic clk = 1'b0;
    logic srst;
    logic in_a;
    logic in_b;
    logic z_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  ref_z    = 0;
    int  ref_prev = 3;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    seq_set_clear_toggle uut (
        .clk   (clk),
        .srst  (srst),
        .in_a  (in_a),
        .in_b  (in_b),
        .z_out (z_out)
    );

    task automatic check(string tag, logic act, int exp);
        n_checks++;
        if (act !== exp[0]) begin
            n_fail++;
            $display("FAIL %s: z_out=%0b expected %0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic step(bit a, bit b, string force_tag = "");
        int    cur = 2 * int'(a) + int'(b);
        string tag;
        in_a = a;
        in_b = b;
        #1;
        check("R1", z_out, ref_z);
        if (cur != 3)           tag = "R2";
        else if (ref_prev == 0) tag = "R3";
        else if (ref_prev == 1) tag = "R4";
        else if (ref_prev == 2) tag = "R5";
        else                    tag = "R6";
        if (force_tag != "") tag = force_tag;
        @(posedge clk);
        if (cur == 3) begin
            if (ref_prev == 0)      ref_z = 0;
            else if (ref_prev == 1) ref_z = 1;
            else if (ref_prev == 2) ref_z = 1 - ref_z;
        end
        ref_prev = cur;
        @(negedge clk);
        check(tag, z_out, ref_z);
    endtask

    task automatic do_reset();
        srst = 1'b1;
        @(posedge clk);
        ref_z    = 0;
        ref_prev = 3;
        @(negedge clk);
        check("R7", z_out, 0);
        srst = 1'b0;
    endtask

    initial begin
        srst = 1'b1;
        in_a = 1'b0;
        in_b = 1'b0;
        @(negedge clk);
        do_reset();
        step(1, 1, "R7");             // first 11 after reset holds 0
        step(0, 1); step(1, 1);       // set R4
        step(1, 1);                   // repeat holds R6
        step(0, 0); step(1, 1);       // clear R3
        step(1, 0); step(1, 1);       // toggle R5 -> 1
        step(1, 0); step(1, 1);       // toggle R5 -> 0, overlapping R6
        step(0, 0); step(0, 1); step(1, 0); step(0, 1); step(1, 1); // R2 then R4
        step(0, 0); step(0, 0); step(1, 0); step(1, 0);             // R2 holds 1
        do_reset();                   // clears a high level R7
        step(0, 1); step(1, 1);       // set again
        step(0, 0); do_reset();       // reset right after a 00
        step(1, 0); do_reset();       // discard a pending toggle
        step(1, 1, "R7");             // must stay 0
        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom_range(1)), 1'($urandom_range(1)));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule